// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block issues the conversion-start handshake for an external simultaneous-sampling converter from a synchronous system clock. For each accepted request it drives the conversion-start line low and then high. It then waits for the converter's busy flag to rise and to fall, and it lowers an active-low chip select to frame the readout. Chip select stays low until the downstream reader reports completion. After that the block waits out a quiet interval before it may start another conversion.

Every interval is a cycle count. The block derives each count from a nanosecond figure and the `CLK_PERIOD_NS` parameter, rounding up to whole cycles. Intervals are measured on the block's own clock. The asynchronous busy input passes through a synchronizer of configurable depth. In hardware channel mode a 3-bit channel-pair select is captured when a request is accepted. It is presented ahead of the start edge and held through it. Requests that arrive mid-cycle are remembered and serviced as soon as every interval allows. A busy flag that never rises or never falls ends the cycle with a one-cycle error pulse.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset, `convst` is 0, `cs_n` is 1, `err` is 0 and `ch_sel` is 0.
- R2: Before each rising edge of `convst` the line has been low for at least ceil(50 ns / period) cycles. Each high pulse lasts at least ceil(50 ns / period) cycles.
- R3: Two rising edges of `convst` are at least ceil(1000 ns / period) cycles apart.
- R4: `cs_n` falls only while busy is low. The fall comes at least ceil(20 ns / period) cycles after busy fell, and only after busy rose and fell for the current conversion. `cs_n` is never low while `convst` is high.
- R5: At least ceil(50 ns / period) cycles pass from a rise of `cs_n` to the next rising edge of `convst`.
- R6: With `HW_CHAN` set, `ch_sel` takes the value of `ch_sel_in` sampled in the cycle a request is accepted. It is stable for at least ceil(50 ns / period) cycles before the rising edge of `convst`, and it does not change until the next request is accepted.
- R7: Once low, `cs_n` stays low until `read_done` is sampled high. It is high in the cycle after that sample.
- R8: If synchronized busy is not seen high within ceil(100 ns / period) + SYNC_STAGES cycles of the rising edge, `err` pulses for one cycle, `cs_n` stays high and the block returns to idle.
- R9: If synchronized busy is not seen low within ceil(1000 ns / period) + SYNC_STAGES cycles of the rising edge, `err` pulses for one cycle, `cs_n` stays high and the block returns to idle.
- R10: A `start_req` pulse that arrives while a cycle is in progress is held and serviced after that cycle. Several pulses during one cycle yield exactly one further conversion.
- R11: Without a request, `convst` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | One-cycle conversion request |
| ch_sel_in | input | CH_W | Channel-pair index to use for the next accepted request |
| busy | input | 1 | Converter busy flag (asynchronous) |
| read_done | input | 1 | Readout complete; ends the chip-select frame |
| convst | output | 1 | Conversion-start line to the converter |
| cs_n | output | 1 | Active-low chip select framing the readout |
| ch_sel | output | CH_W | Channel-pair select bus (hardware channel mode) |
| err | output | 1 | One-cycle pulse on a busy timeout |

## Verification
The bench runs four kinds of stimulus. A lone request checks pulse widths, the busy-to-select gap and the read handshake. Several requests packed into one cycle check that a pending request is held, that repeats are merged, and that start-to-start spacing and the quiet gap are enforced. Changing `ch_sel_in` after acceptance separates a select captured at acceptance from one that follows its input. A converter model that never raises busy, and one that never drops it, separates the two timeout paths. Each of them must end in an error pulse with no frame and a clean recovery.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_CH_SETUP,
      S_CONV_LOW,
      S_CONV_HIGH,
      S_WAIT_BUSY_HI,
      S_WAIT_BUSY_LO,
      S_CS_SETUP,
      S_READ,
      S_QUIET
   } trig_state_e;

   // ceil(ns / period), never below one cycle
   function automatic int ns_to_cyc(input int ns, input int period);
      int c;
      c = (ns + period - 1) / period;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[STAGES-2+((STAGES>1)?0:1):0] , d} >> ((STAGES>1)?0:0);
         end
         assign q = sr[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/trig_sat_cnt.sv
module trig_sat_cnt #(
   parameter int           W       = 4,
   parameter logic [W-1:0] TOP     = '1,
   parameter bit           RST_TOP = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= RST_TOP ? TOP : '0;
      else if (clr)         cnt <= '0;
      else if (cnt != TOP)  cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/trig_req_hold.sv
module trig_req_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic take,
   output logic req_any
);

   logic pend;

   assign req_any = pend | req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= req_any & ~take;
   end

   AST_REQ_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !take) |=> pend);   // R10

endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
   import adc_trig_pkg::*;
#(
   parameter int CLK_PERIOD_NS  = 10,
   parameter int CH_W           = 3,
   parameter bit HW_CHAN        = 1'b1,
   parameter int SYNC_STAGES    = 2,
   parameter int T_LOW_NS       = 50,
   parameter int T_HIGH_NS      = 50,
   parameter int T_CYCLE_NS     = 1000,
   parameter int T_CS_SETUP_NS  = 20,
   parameter int T_QUIET_NS     = 50,
   parameter int T_CH_SETUP_NS  = 50,
   parameter int T_BUSY_HI_NS   = 100,
   parameter int T_BUSY_LO_NS   = 1000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_req,
   input  logic [CH_W-1:0] ch_sel_in,
   input  logic            busy,
   input  logic            read_done,
   output logic            convst,
   output logic            cs_n,
   output logic [CH_W-1:0] ch_sel,
   output logic            err
);

   // ---- derived cycle counts ----
   localparam int LOW_C   = ns_to_cyc(T_LOW_NS,      CLK_PERIOD_NS);
   localparam int HIGH_C  = ns_to_cyc(T_HIGH_NS,     CLK_PERIOD_NS);
   localparam int CYC_C   = ns_to_cyc(T_CYCLE_NS,    CLK_PERIOD_NS);
   localparam int CSS_C   = ns_to_cyc(T_CS_SETUP_NS, CLK_PERIOD_NS);
   localparam int QUIET_C = ns_to_cyc(T_QUIET_NS,    CLK_PERIOD_NS);
   localparam int CHS_C   = ns_to_cyc(T_CH_SETUP_NS, CLK_PERIOD_NS);
   localparam int BHI_C   = ns_to_cyc(T_BUSY_HI_NS,  CLK_PERIOD_NS) + SYNC_STAGES;
   localparam int BLO_C   = ns_to_cyc(T_BUSY_LO_NS,  CLK_PERIOD_NS) + SYNC_STAGES;

   localparam int DW_MAX  = max2(max2(max2(LOW_C, HIGH_C), max2(CSS_C, QUIET_C)), CHS_C);
   localparam int SS_MAX  = max2(max2(CYC_C, BLO_C), BHI_C);
   localparam int DW_W    = $clog2(DW_MAX + 1);
   localparam int SS_W    = $clog2(SS_MAX + 1);

   localparam logic [DW_W-1:0] DW_TOP  = DW_W'(DW_MAX);
   localparam logic [SS_W-1:0] SS_TOP  = SS_W'(SS_MAX);
   localparam logic [DW_W-1:0] LOW_T   = DW_W'(LOW_C - 1);
   localparam logic [DW_W-1:0] HIGH_T  = DW_W'(HIGH_C - 1);
   localparam logic [DW_W-1:0] CSS_T   = DW_W'(CSS_C - 1);
   localparam logic [DW_W-1:0] QUIET_T = DW_W'(QUIET_C - 1);
   localparam logic [DW_W-1:0] CHS_T   = DW_W'(CHS_C - 1);
   localparam logic [SS_W-1:0] CYC_T   = SS_W'(CYC_C - 1);
   localparam logic [SS_W-1:0] BHI_T   = SS_W'(BHI_C - 1);
   localparam logic [SS_W-1:0] BLO_T   = SS_W'(BLO_C - 1);

   // ---- elaboration checks ----
   generate
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("adc_trig_seq: CLK_PERIOD_NS must be positive");
      end
      if (CH_W < 1) begin : g_bad_chw
         $error("adc_trig_seq: CH_W must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("adc_trig_seq: SYNC_STAGES must be 0..4");
      end
      if (T_BUSY_LO_NS <= T_BUSY_HI_NS) begin : g_bad_to
         $error("adc_trig_seq: busy-low timeout must exceed busy-high timeout");
      end
   endgenerate

   // ---- state and helpers ----
   trig_state_e st, st_nxt;
   logic        busy_s;
   logic        take;
   logic        req_any;
   logic        err_nxt;
   logic        rise_nxt;
   logic [DW_W-1:0] dw;
   logic [SS_W-1:0] ss;

   trig_sync #(.STAGES(SYNC_STAGES)) i_busy_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (busy),
      .q     (busy_s)
   );

   trig_req_hold i_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (start_req),
      .take    (take),
      .req_any (req_any)
   );

   // cycles spent in the current state
   trig_sat_cnt #(.W(DW_W), .TOP(DW_TOP), .RST_TOP(1'b0)) i_dwell (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_nxt != st),
      .cnt   (dw)
   );

   // cycles since the last rising edge of convst (saturated after reset)
   trig_sat_cnt #(.W(SS_W), .TOP(SS_TOP), .RST_TOP(1'b1)) i_since (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rise_nxt),
      .cnt   (ss)
   );

   assign take     = (st == S_IDLE) && req_any;
   assign rise_nxt = (st_nxt == S_CONV_HIGH) && (st != S_CONV_HIGH);

   always_comb begin
      st_nxt  = st;
      err_nxt = 1'b0;
      unique case (st)
         S_IDLE:
            if (req_any) st_nxt = HW_CHAN ? S_CH_SETUP : S_CONV_LOW;
         S_CH_SETUP:
            if (dw >= CHS_T) st_nxt = S_CONV_LOW;
         S_CONV_LOW:
            if (dw >= LOW_T && ss >= CYC_T) st_nxt = S_CONV_HIGH;
         S_CONV_HIGH:
            if (dw >= HIGH_T) st_nxt = S_WAIT_BUSY_HI;
         S_WAIT_BUSY_HI:
            if (busy_s) st_nxt = S_WAIT_BUSY_LO;
            else if (ss >= BHI_T) begin
               st_nxt  = S_IDLE;
               err_nxt = 1'b1;
            end
         S_WAIT_BUSY_LO:
            if (!busy_s) st_nxt = S_CS_SETUP;
            else if (ss >= BLO_T) begin
               st_nxt  = S_IDLE;
               err_nxt = 1'b1;
            end
         S_CS_SETUP:
            if (dw >= CSS_T) st_nxt = S_READ;
         S_READ:
            if (read_done) st_nxt = S_QUIET;
         S_QUIET:
            if (dw >= QUIET_T) st_nxt = S_IDLE;
         default:
            st_nxt = S_IDLE;
      endcase
   end

   // state and registered outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         convst <= 1'b0;
         cs_n   <= 1'b1;
         err    <= 1'b0;
      end else begin
         st     <= st_nxt;
         convst <= (st_nxt == S_CONV_HIGH);
         cs_n   <= (st_nxt != S_READ);
         err    <= err_nxt;
      end
   end

   // channel-pair select capture
   generate
      if (HW_CHAN) begin : g_chan
         logic [CH_W-1:0] ch_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    ch_q <= '0;
            else if (take) ch_q <= ch_sel_in;
         end
         assign ch_sel = ch_q;

         AST_CHSEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (st != S_IDLE) |=> $stable(ch_sel));   // R6
      end else begin : g_nochan
         assign ch_sel = '0;
      end
   endgenerate

   // ---- assertions ----
   AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(convst) |-> ($past(dw) >= HIGH_T));   // R2

   AST_RISE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(convst) |-> ($past(ss) >= CYC_T));   // R3

   AST_CS_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> !busy_s);   // R4

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(convst && !cs_n));   // R4

   AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> cs_n);   // R8

   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);   // R9

endmodule

// File: tb/test_adc_trig_seq.sv
`timescale 1ns/1ps
module test_adc_trig_seq;

   localparam int PER     = 20;
   localparam int LOW_C   = 3;
   localparam int HIGH_C  = 3;
   localparam int CYC_C   = 50;
   localparam int CSS_C   = 1;
   localparam int QUIET_C = 3;
   localparam int CHS_C   = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_req = 1'b0;
   logic [2:0] ch_sel_in = 3'd0;
   logic       busy = 1'b0;
   logic       read_done = 1'b0;
   logic       convst, cs_n, err;
   logic [2:0] ch_sel;

   int n_chk = 0, n_fail = 0;
   int adc_mode = 0;
   int cyc = 0;
   int n_rise = 0, n_frames = 0, n_err = 0;
   int t_rise = -1000, t_cfall = -1000, t_csrise = -1000, t_bfall = -1000, t_chg = -1000;
   logic [2:0] exp_ch = 3'd0;
   logic p_convst = 1'b0, p_cs_n = 1'b1, p_busy = 1'b0;
   logic [2:0] p_ch = 3'd0;
   bit mon_on = 1'b0;
   bit done = 1'b0;

   always #(PER/2) clk = ~clk;

   adc_trig_seq #(.CLK_PERIOD_NS(PER), .CH_W(3), .HW_CHAN(1'b1), .SYNC_STAGES(2)) i_adc_trig_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (start_req),
      .ch_sel_in (ch_sel_in),
      .busy      (busy),
      .read_done (read_done),
      .convst    (convst),
      .cs_n      (cs_n),
      .ch_sel    (ch_sel),
      .err       (err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // converter model
   initial begin
      forever begin
         @(posedge convst);
         if (adc_mode == 0) begin
            #20 busy = 1'b1;
            #500 busy = 1'b0;
         end else if (adc_mode == 2) begin
            #20 busy = 1'b1;
         end
      end
   end

   // reader model: ends the frame a few cycles after cs_n falls
   initial begin
      forever begin
         @(negedge cs_n);
         repeat (4) @(negedge clk);
         check(cs_n == 1'b0, "R7 cs held low", cs_n, 0);
         read_done = 1'b1;
         @(negedge clk);
         read_done = 1'b0;
         check(cs_n == 1'b1, "R7 cs released", cs_n, 1);
      end
   end

   // interval monitor
   always @(negedge clk) begin
      cyc++;
      if (mon_on) begin
         if (p_busy && !busy) t_bfall = cyc;
         if (ch_sel != p_ch)  t_chg = cyc;
         if (!p_convst && convst) begin
            n_rise++;
            if (n_rise > 1) check(cyc - t_rise >= CYC_C, "R3 start spacing", cyc - t_rise, CYC_C);
            check(cyc - t_cfall >= LOW_C, "R2 low width", cyc - t_cfall, LOW_C);
            check(cyc - t_csrise >= QUIET_C, "R5 quiet gap", cyc - t_csrise, QUIET_C);
            check(cyc - t_chg >= CHS_C, "R6 chsel setup", cyc - t_chg, CHS_C);
            check(ch_sel == exp_ch, "R6 chsel value", ch_sel, exp_ch);
            t_rise = cyc;
         end
         if (p_convst && !convst) begin
            check(cyc - t_rise >= HIGH_C, "R2 high width", cyc - t_rise, HIGH_C);
            t_cfall = cyc;
         end
         if (p_cs_n && !cs_n) begin
            n_frames++;
            check(busy == 1'b0, "R4 busy low at cs", busy, 0);
            check(t_bfall > t_rise && cyc - t_bfall >= CSS_C, "R4 busy-to-cs gap", cyc - t_bfall, CSS_C);
         end
         if (!p_cs_n && cs_n) t_csrise = cyc;
         if (err) n_err++;
      end
      p_convst = convst; p_cs_n = cs_n; p_busy = busy; p_ch = ch_sel;
   end

   task automatic pulse_req();
      @(negedge clk); start_req = 1'b1;
      @(negedge clk); start_req = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check(convst == 1'b0, "R1 convst", convst, 0);
      check(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
      check(err == 1'b0, "R1 err", err, 0);
      check(ch_sel == 3'd0, "R1 ch_sel", ch_sel, 0);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;
   endtask

   task automatic t_idle();
      int r0 = n_rise;
      repeat (100) @(negedge clk);
      check(n_rise == r0, "R11 no request no start", n_rise - r0, 0);
   endtask

   task automatic t_single(input logic [2:0] ch);
      int r0 = n_rise, f0 = n_frames, e0 = n_err;
      adc_mode = 0; ch_sel_in = ch; exp_ch = ch;
      pulse_req();
      repeat (150) @(negedge clk);
      check(n_rise == r0 + 1, "R2 one start", n_rise - r0, 1);
      check(n_frames == f0 + 1, "R4 one frame", n_frames - f0, 1);
      check(n_err == e0, "R8 no error", n_err - e0, 0);
      check(cs_n == 1'b1 && convst == 1'b0, "R7 idle after frame", {convst, cs_n}, 1);
   endtask

   task automatic t_back2back();
      int r0 = n_rise, f0 = n_frames;
      adc_mode = 0; ch_sel_in = 3'd1; exp_ch = 3'd1;
      pulse_req();
      repeat (10) @(negedge clk);
      pulse_req();
      repeat (5) @(negedge clk);
      pulse_req();
      repeat (300) @(negedge clk);
      check(n_rise == r0 + 2, "R10 held request merged", n_rise - r0, 2);
      check(n_frames == f0 + 2, "R10 two frames", n_frames - f0, 2);
   endtask

   task automatic t_chsel();
      adc_mode = 0; ch_sel_in = 3'd3; exp_ch = 3'd3;
      pulse_req();
      repeat (2) @(negedge clk);
      ch_sel_in = 3'd6;
      repeat (150) @(negedge clk);
      check(ch_sel == 3'd3, "R6 chsel captured at accept", ch_sel, 3);
      exp_ch = 3'd6;
      pulse_req();
      repeat (150) @(negedge clk);
      check(ch_sel == 3'd6, "R6 chsel next request", ch_sel, 6);
   endtask

   task automatic t_no_busy();
      int f0 = n_frames, e0 = n_err;
      adc_mode = 1; ch_sel_in = 3'd2; exp_ch = 3'd2;
      pulse_req();
      repeat (100) @(negedge clk);
      check(n_err == e0 + 1, "R8 busy-rise timeout", n_err - e0, 1);
      check(n_frames == f0, "R8 no frame", n_frames - f0, 0);
      check(convst == 1'b0 && cs_n == 1'b1, "R8 back to idle", {convst, cs_n}, 1);
   endtask

   task automatic t_stuck_busy();
      int f0 = n_frames, e0 = n_err;
      adc_mode = 2; ch_sel_in = 3'd4; exp_ch = 3'd4;
      pulse_req();
      repeat (150) @(negedge clk);
      check(n_err == e0 + 1, "R9 busy-fall timeout", n_err - e0, 1);
      check(n_frames == f0, "R9 no frame", n_frames - f0, 0);
      busy = 1'b0;
      adc_mode = 0;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_idle();
      t_single(3'd5);
      t_back2back();
      t_chsel();
      t_no_busy();
      t_single(3'd7);
      t_stuck_busy();
      t_single(3'd0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule